// File: doc/BRIEF.md
# Banked Software Write-Lock Sequencer

This block sits beside the page loader of a banked non-volatile word memory. It watches each word write, which arrives as a bank number, the low fifteen word-address bits and a sixteen-bit data word. It keeps one software lock flag for each bank. In the cycle the write is presented, it tells the loader whether to store that word.

A short unlock prefix of three fixed address/data pairs opens a load window in a bank. If the bank was unlocked, the prefix also arms the lock. A six-word release sequence opens a window and arms removal of the lock. The lock change takes effect when the loader reports the end of its write period (`period_done`), whether or not any data words were loaded. While a bank is locked, a write that did not follow the prefix is refused. The loader still runs its write timer for such a write, but nothing is stored.

Each bank has its own sequence tracker, which uses these named states and transitions:
- `ST_IDLE` → `ST_P1` on AAAA at 5555.
- `ST_P1` → `ST_P2` on 5555 at 2AAA.
- `ST_P2` → `ST_OPEN` on A0A0 at 5555 (arms lock). `ST_P2` → `ST_R3` on 8080 at 5555.
- `ST_R3` → `ST_R4` on AAAA at 5555.
- `ST_R4` → `ST_R5` on 5555 at 2AAA.
- `ST_R5` → `ST_OPEN` on 2020 at 5555 (arms release).
- Any mismatching write in a matching state → `ST_IDLE`.
- `period_done` takes every bank to `ST_IDLE`, and a bank in `ST_OPEN` applies its armed change at that point.

Top module: `swp_seq`

## Requirements
- R1: After reset every bank's lock flag is 0. A write that is not a command word and goes to an unlocked bank drives `wr_store` high in the same cycle.
- R2: A write that matches the next step of its bank's sequence drives `wr_cmd` high and `wr_store` low. Matching compares `wr_word` (address bits 14..0) and the full 16-bit data.
- R3: The prefix AAAA@5555, 5555@2AAA, A0A0@5555 followed by `period_done`, with no data words between, sets the bank's flag (bit b of `prot_flags` for bank b).
- R4: A non-command write to a locked bank outside an open window gives `wr_store`=0 and `wr_cmd`=0, and the flag stays set.
- R5: After the prefix, data writes to a locked bank are stored. The flag is still set after `period_done`.
- R6: Within one window, the first PAGE_WORDS (128) data writes are stored. Later writes in that window are stored only if the bank is unlocked.
- R7: The sequence AAAA@5555, 5555@2AAA, 8080@5555, AAAA@5555, 5555@2AAA, 2020@5555 followed by `period_done` clears the flag. A plain write to the bank is stored after that.
- R8: A write that breaks a partial sequence returns the bank to idle and is handled as data under the current flag. A following step-two word is then data too.
- R9: Flags and sequence progress are kept per bank. Writes to other banks between the steps of a sequence neither advance it nor break it.
- R10: `period_done` drops any partial sequence, so the next step-two word is handled as data.
- R11: `prot_flags` changes only at a clock edge where `period_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; all flags cleared |
| wr_en | input | 1 | A word write is presented this cycle |
| wr_bank | input | BANK_BITS | Bank addressed by the write |
| wr_word | input | 15 | Word address bits 14..0 used for matching |
| wr_data | input | 16 | Write data word |
| period_done | input | 1 | End of the loader's write period |
| wr_store | output | 1 | Store the presented word |
| wr_cmd | output | 1 | Presented word was consumed as a command step |
| prot_flags | output | 2**BANK_BITS | Lock flag for each bank |

## Verification
The sequences are tried in several forms: complete prefixes with and without data words, the complete release sequence, a prefix broken halfway by a stray word, and sequences spread over two banks with writes to other banks placed between their steps. Refusal of a plain write to a locked bank shows that the flag gates storage. A stray word followed by a step-two word shows that a broken sequence goes back to idle and does not resume. A window filled to 129 words shows where the page limit applies. A partial sequence cut by `period_done` shows that trackers are cleared at the end of a period, and a reset in mid-run shows that all flags are cleared.

// File: rtl/swp_pkg.sv
package swp_pkg;
    localparam int MATCH_W = 15;
    localparam int DATA_W  = 16;

    localparam logic [MATCH_W-1:0] ADR_HI = 15'h5555;
    localparam logic [MATCH_W-1:0] ADR_LO = 15'h2AAA;

    localparam logic [DATA_W-1:0] KEY_A   = 16'hAAAA;
    localparam logic [DATA_W-1:0] KEY_5   = 16'h5555;
    localparam logic [DATA_W-1:0] KEY_LCK = 16'hA0A0;
    localparam logic [DATA_W-1:0] KEY_REL = 16'h8080;
    localparam logic [DATA_W-1:0] KEY_FIN = 16'h2020;

    typedef enum logic [2:0] {
        ST_IDLE, ST_P1, ST_P2, ST_R3, ST_R4, ST_R5, ST_OPEN
    } seq_st_t;
endpackage

// File: rtl/swp_step.sv
module swp_step
    import swp_pkg::*;
(
    input  seq_st_t             st,
    input  logic [MATCH_W-1:0]  word,
    input  logic [DATA_W-1:0]   data,
    output logic                hit,
    output seq_st_t             nxt,
    output logic                arm_lock,
    output logic                arm_rel
);
    logic at_hi, at_lo;

    assign at_hi = (word == ADR_HI);
    assign at_lo = (word == ADR_LO);

    always_comb begin
        hit      = 1'b0;
        nxt      = ST_IDLE;
        arm_lock = 1'b0;
        arm_rel  = 1'b0;
        unique case (st)
            ST_IDLE: begin
                hit = at_hi && data == KEY_A;
                nxt = ST_P1;
            end
            ST_P1: begin
                hit = at_lo && data == KEY_5;
                nxt = ST_P2;
            end
            ST_P2: begin
                if (at_hi && data == KEY_LCK) begin
                    hit      = 1'b1;
                    nxt      = ST_OPEN;
                    arm_lock = 1'b1;
                end else if (at_hi && data == KEY_REL) begin
                    hit = 1'b1;
                    nxt = ST_R3;
                end
            end
            ST_R3: begin
                hit = at_hi && data == KEY_A;
                nxt = ST_R4;
            end
            ST_R4: begin
                hit = at_lo && data == KEY_5;
                nxt = ST_R5;
            end
            ST_R5: begin
                hit     = at_hi && data == KEY_FIN;
                nxt     = ST_OPEN;
                arm_rel = hit;
            end
            ST_OPEN: begin
                hit = 1'b0;
                nxt = ST_OPEN;
            end
            default: begin
                hit = 1'b0;
                nxt = ST_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/swp_bank.sv
module swp_bank
    import swp_pkg::*;
#(
    parameter int PAGE_WORDS = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel,
    input  logic [MATCH_W-1:0]  word,
    input  logic [DATA_W-1:0]   data,
    input  logic                period_done,
    output logic                store,
    output logic                is_cmd,
    output logic                prot
);
    localparam int CW = $clog2(PAGE_WORDS + 1);

    seq_st_t        st_q;
    seq_st_t        st_nxt;
    logic           hit, arm_lock, arm_rel;
    logic           pend_lock_q, pend_rel_q;
    logic [CW-1:0]  cnt_q;
    logic           room;

    swp_step i_step (
        .st       (st_q),
        .word     (word),
        .data     (data),
        .hit      (hit),
        .nxt      (st_nxt),
        .arm_lock (arm_lock),
        .arm_rel  (arm_rel)
    );

    assign room = (cnt_q < CW'(PAGE_WORDS));

    // outputs for the write presented this cycle
    always_comb begin
        is_cmd = sel && (st_q != ST_OPEN) && hit;
        store  = sel && !is_cmd && (((st_q == ST_OPEN) && room) || !prot);
    end

    // state register and flag update
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            pend_lock_q <= 1'b0;
            pend_rel_q  <= 1'b0;
            cnt_q       <= '0;
            prot        <= 1'b0;
        end else if (period_done) begin
            if (st_q == ST_OPEN) begin
                if (pend_lock_q)     prot <= 1'b1;
                else if (pend_rel_q) prot <= 1'b0;
            end
            st_q        <= ST_IDLE;
            pend_lock_q <= 1'b0;
            pend_rel_q  <= 1'b0;
            cnt_q       <= '0;
        end else if (sel) begin
            if (st_q == ST_OPEN) begin
                if (room) cnt_q <= cnt_q + 1'b1;
            end else if (hit) begin
                st_q <= st_nxt;
                if (arm_lock) pend_lock_q <= 1'b1;
                if (arm_rel)  pend_rel_q  <= 1'b1;
                cnt_q <= '0;
            end else begin
                st_q <= ST_IDLE;
            end
        end
    end
endmodule

// File: rtl/swp_seq.sv
module swp_seq
    import swp_pkg::*;
#(
    parameter int BANK_BITS  = 2,
    parameter int PAGE_WORDS = 128
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [BANK_BITS-1:0]        wr_bank,
    input  logic [MATCH_W-1:0]          wr_word,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic                        period_done,
    output logic                        wr_store,
    output logic                        wr_cmd,
    output logic [(1<<BANK_BITS)-1:0]   prot_flags
);
    localparam int NB = 1 << BANK_BITS;

    logic [NB-1:0] sel_v, store_v, cmd_v;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        assign sel_v[b] = wr_en && (wr_bank == BANK_BITS'(b));

        swp_bank #(.PAGE_WORDS(PAGE_WORDS)) i_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .sel         (sel_v[b]),
            .word        (wr_word),
            .data        (wr_data),
            .period_done (period_done),
            .store       (store_v[b]),
            .is_cmd      (cmd_v[b]),
            .prot        (prot_flags[b])
        );
    end

    assign wr_store = |store_v;
    assign wr_cmd   = |cmd_v;
endmodule

// File: rtl/swp_chk.sv
module swp_chk #(
    parameter int BANK_BITS = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        wr_en,
    input logic [BANK_BITS-1:0]        wr_bank,
    input logic                        period_done,
    input logic                        wr_store,
    input logic                        wr_cmd,
    input logic [(1<<BANK_BITS)-1:0]   prot_flags
);
    a_r2_cmd_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd |-> !wr_store);

    a_r2_outputs_need_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_store || wr_cmd) |-> wr_en);

    a_r1_unlocked_bank_stores: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_cmd && !prot_flags[wr_bank]) |-> wr_store);

    a_r11_flags_move_on_period: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prot_flags) |-> $past(period_done));
endmodule

bind swp_seq swp_chk #(.BANK_BITS(BANK_BITS)) i_swp_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_bank     (wr_bank),
    .period_done (period_done),
    .wr_store    (wr_store),
    .wr_cmd      (wr_cmd),
    .prot_flags  (prot_flags)
);

// File: tb/test_swp_seq.sv
module test_swp_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_bank = '0;
    logic [14:0] wr_word = '0;
    logic [15:0] wr_data = '0;
    logic        period_done = 1'b0;
    logic        wr_store, wr_cmd;
    logic [3:0]  prot_flags;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    swp_seq i_swp_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank),
        .wr_word(wr_word), .wr_data(wr_data), .period_done(period_done),
        .wr_store(wr_store), .wr_cmd(wr_cmd), .prot_flags(prot_flags)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one write, check same-cycle outputs, then flags after the edge
    task automatic do_wr(input logic [1:0] b, input logic [14:0] a, input logic [15:0] d,
                         input bit es, input bit ec, input logic [3:0] ef, input string req);
        @(negedge clk);
        wr_en = 1'b1; wr_bank = b; wr_word = a; wr_data = d;
        #1;
        check(wr_store == es, {req, " store"}, int'(wr_store), int'(es));
        check(wr_cmd == ec, {req, " cmd"}, int'(wr_cmd), int'(ec));
        @(posedge clk); #1;
        wr_en = 1'b0;
        check(prot_flags == ef, {req, " flags"}, int'(prot_flags), int'(ef));
    endtask

    task automatic do_period(input logic [3:0] ef, input string req);
        @(negedge clk);
        period_done = 1'b1;
        @(posedge clk); #1;
        period_done = 1'b0;
        check(prot_flags == ef, {req, " flags"}, int'(prot_flags), int'(ef));
    endtask

    // {op(1=period), bank, word, data, store, cmd, flags_after}
    localparam int NV = 31;
    localparam logic [39:0] VEC [NV] = '{
        {1'b0, 2'd0, 15'h5555, 16'hAAAA, 1'b0, 1'b1, 4'h0}, // R2
        {1'b0, 2'd0, 15'h2AAA, 16'h5555, 1'b0, 1'b1, 4'h0}, // R2
        {1'b0, 2'd0, 15'h5555, 16'hA0A0, 1'b0, 1'b1, 4'h0}, // R3 R11
        {1'b1, 2'd0, 15'h0000, 16'h0000, 1'b0, 1'b0, 4'h1}, // R3
        {1'b0, 2'd0, 15'h0100, 16'h1234, 1'b0, 1'b0, 4'h1}, // R4
        {1'b0, 2'd1, 15'h0100, 16'h1234, 1'b1, 1'b0, 4'h1}, // R9
        {1'b0, 2'd0, 15'h5555, 16'hAAAA, 1'b0, 1'b1, 4'h1}, // R5
        {1'b0, 2'd1, 15'h0010, 16'h0001, 1'b1, 1'b0, 4'h1}, // R9 interleave
        {1'b0, 2'd0, 15'h2AAA, 16'h5555, 1'b0, 1'b1, 4'h1}, // R9
        {1'b0, 2'd0, 15'h5555, 16'hA0A0, 1'b0, 1'b1, 4'h1}, // R5
        {1'b0, 2'd0, 15'h0200, 16'hBEEF, 1'b1, 1'b0, 4'h1}, // R5
        {1'b0, 2'd0, 15'h0201, 16'hBEEF, 1'b1, 1'b0, 4'h1}, // R5
        {1'b1, 2'd0, 15'h0000, 16'h0000, 1'b0, 1'b0, 4'h1}, // R5
        {1'b0, 2'd0, 15'h5555, 16'hAAAA, 1'b0, 1'b1, 4'h1}, // R8
        {1'b0, 2'd0, 15'h1234, 16'h0000, 1'b0, 1'b0, 4'h1}, // R8 break
        {1'b0, 2'd0, 15'h2AAA, 16'h5555, 1'b0, 1'b0, 4'h1}, // R8 no resume
        {1'b0, 2'd0, 15'h5555, 16'hAAAA, 1'b0, 1'b1, 4'h1}, // R7
        {1'b0, 2'd0, 15'h2AAA, 16'h5555, 1'b0, 1'b1, 4'h1}, // R7
        {1'b0, 2'd0, 15'h5555, 16'h8080, 1'b0, 1'b1, 4'h1}, // R7
        {1'b0, 2'd0, 15'h5555, 16'hAAAA, 1'b0, 1'b1, 4'h1}, // R7
        {1'b0, 2'd0, 15'h2AAA, 16'h5555, 1'b0, 1'b1, 4'h1}, // R7
        {1'b0, 2'd0, 15'h5555, 16'h2020, 1'b0, 1'b1, 4'h1}, // R7 R11
        {1'b1, 2'd0, 15'h0000, 16'h0000, 1'b0, 1'b0, 4'h0}, // R7
        {1'b0, 2'd0, 15'h0300, 16'h1111, 1'b1, 1'b0, 4'h0}, // R7
        {1'b0, 2'd2, 15'h5555, 16'hAAAA, 1'b0, 1'b1, 4'h0}, // R9
        {1'b0, 2'd3, 15'h5555, 16'hAAAA, 1'b0, 1'b1, 4'h0}, // R10
        {1'b0, 2'd2, 15'h2AAA, 16'h5555, 1'b0, 1'b1, 4'h0}, // R9
        {1'b0, 2'd2, 15'h5555, 16'hA0A0, 1'b0, 1'b1, 4'h0}, // R9
        {1'b1, 2'd0, 15'h0000, 16'h0000, 1'b0, 1'b0, 4'h4}, // R9
        {1'b0, 2'd3, 15'h2AAA, 16'h5555, 1'b1, 1'b0, 4'h4}, // R10
        {1'b0, 2'd2, 15'h0400, 16'h2222, 1'b0, 1'b0, 4'h4}  // R9 R4
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(prot_flags == 4'h0, "R1 reset flags", int'(prot_flags), 0);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [39:0] v;
            v = VEC[i];
            if (v[39]) do_period(v[3:0], $sformatf("vec%0d", i));
            else do_wr(v[38:37], v[36:22], v[21:6], v[5], v[4], v[3:0],
                       $sformatf("vec%0d", i));
        end

        // R6: lock bank 1, then overfill one window
        do_wr(2'd1, 15'h5555, 16'hAAAA, 1'b0, 1'b1, 4'h4, "R6 p1");
        do_wr(2'd1, 15'h2AAA, 16'h5555, 1'b0, 1'b1, 4'h4, "R6 p2");
        do_wr(2'd1, 15'h5555, 16'hA0A0, 1'b0, 1'b1, 4'h4, "R6 p3");
        do_period(4'h6, "R6 lock");
        do_wr(2'd1, 15'h5555, 16'hAAAA, 1'b0, 1'b1, 4'h6, "R6 q1");
        do_wr(2'd1, 15'h2AAA, 16'h5555, 1'b0, 1'b1, 4'h6, "R6 q2");
        do_wr(2'd1, 15'h5555, 16'hA0A0, 1'b0, 1'b1, 4'h6, "R6 q3");
        for (int w = 0; w < 128; w++)
            do_wr(2'd1, 15'(w), 16'(w), 1'b1, 1'b0, 4'h6, "R6 in page");
        do_wr(2'd1, 15'h0080, 16'h0000, 1'b0, 1'b0, 4'h6, "R6 beyond page");
        do_period(4'h6, "R6 stays locked");

        // R11: idle period leaves flags alone
        do_period(4'h6, "R11 idle period");

        // R1: reset in mid-run clears all flags
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk); #1;
        check(prot_flags == 4'h0, "R1 mid reset", int'(prot_flags), 0);
        @(negedge clk) rst_n = 1'b1;
        do_wr(2'd2, 15'h0010, 16'h7777, 1'b1, 1'b0, 4'h0, "R1 store after reset");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule